// File: doc/BRIEF.md
# Two-Pass Flash Code Merger

This block forms the final word of a two-step subranging converter. The first flash pass produces a 7-bit coarse code. The second pass produces a 7-bit fine code from the residue, which has been amplified by 32, so one coarse step equals 32 output LSBs. The fine range spans four coarse steps. This gives roughly one and a half coarse steps of redundancy on each side, and a wrong coarse decision by one step is corrected by the fine pass.

A strobe marks both codes as valid. On the next clock the block presents a 12-bit offset-binary result, with the midpoint of the transfer curve at code 2048. It also presents an overrange flag, a polarity bit that tells overrange from underrange, and a one-cycle done pulse. When the merged value falls outside the output range, the output saturates at full scale. Between strobes all outputs hold.

Top module: `subrange_merge`

## Requirements
- R1: While reset is asserted and after it is released without a strobe, `result` is 0 and `ovf`, `ovf_pos` and `done` are 0.
- R2: One clock after a strobe, `result` equals coarse×32 + fine − 48, provided that value lies in 0..4095.
- R3: When coarse×32 + fine − 48 exceeds 4095, `result` is all ones (4095), `ovf` is 1 and `ovf_pos` is 1.
- R4: When coarse×32 + fine − 48 is below 0, `result` is 0, `ovf` is 1 and `ovf_pos` is 0.
- R5: `done` is high for exactly the one clock that follows each strobe, and is low otherwise.
- R6: Without a strobe, changes on `coarse` and `fine` have no effect: `result`, `ovf` and `ovf_pos` keep their values.
- R7: For an in-range merge, `ovf` and `ovf_pos` are both 0. `ovf_pos` is never 1 while `ovf` is 0.
- R8: A coarse code of 64 with a fine code of 48 yields the midpoint code 2048. A fine code in either redundant band (below 48 or above 79) corrects a coarse code that is off by one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb | input | 1 | Both codes valid this cycle |
| coarse | input | 7 | First-pass flash code |
| fine | input | 7 | Second-pass flash code of the amplified residue |
| result | output | 12 | Merged offset-binary word |
| ovf | output | 1 | Merged value was out of range and has been saturated |
| ovf_pos | output | 1 | 1 for overrange, 0 for underrange |
| done | output | 1 | One-cycle pulse when a new result is presented |

## Verification
Every result, flag and done pulse is due one clock after the strobe. The bench drives a strobe on a falling edge and reads the outputs on the next falling edge. By that time exactly one rising edge has captured the codes. On the falling edge after that, the bench checks that `done` has dropped and that the outputs have not moved, even though the codes were changed with the strobe low. A behavioural converter model turns a target level into a coarse and fine pair, with the coarse code off by −1, 0 or +1 step. The bench then confirms that an in-range target is rebuilt exactly.

// File: rtl/subrange_merge.sv
module subrange_merge #(
  parameter int CODE_W    = 7,
  parameter int GAIN_LOG2 = 5,
  parameter int OUT_W     = 12,
  parameter int OFFSET    = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic [CODE_W-1:0] coarse,
  input  logic [CODE_W-1:0] fine,
  output logic [OUT_W-1:0]  result,
  output logic              ovf,
  output logic              ovf_pos,
  output logic              done
);
  localparam int SUM_W = CODE_W + GAIN_LOG2 + 2;
  localparam logic signed [SUM_W-1:0] TOP  = SUM_W'((2 ** OUT_W) - 1);
  localparam logic signed [SUM_W-1:0] BIAS = SUM_W'(OFFSET);

  logic signed [SUM_W-1:0] sum;
  logic                    under, over;
  logic [OUT_W-1:0]        word;

  assign sum   = $signed({2'b00, coarse, {GAIN_LOG2{1'b0}}})
               + $signed({{(SUM_W-CODE_W){1'b0}}, fine}) - BIAS;
  assign under = sum[SUM_W-1];
  assign over  = !under && (sum > TOP);
  assign word  = under ? '0 : over ? '1 : sum[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      ovf     <= 1'b0;
      ovf_pos <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strb;
      if (strb) begin
        result  <= word;
        ovf     <= under | over;
        ovf_pos <= over;
      end
    end
  end

  p_done_follows_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb |=> done);
  p_no_spurious_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb |=> !done);
  p_hold_without_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb |=> ($stable(result) && $stable(ovf) && $stable(ovf_pos)));
  p_polarity_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> !ovf_pos);
  p_saturate_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ovf_pos) |-> (&result));
  p_saturate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_pos) |-> (result == '0));
endmodule

// File: tb/sim_subrange_merge.sv
module sim_subrange_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strb = 1'b0;
  logic [6:0]  coarse = '0;
  logic [6:0]  fine = '0;
  logic [11:0] result;
  logic        ovf, ovf_pos, done;
  int          checks = 0;
  int          errors = 0;
  bit          ended = 1'b0;

  always #10 clk = ~clk;

  subrange_merge u0 (.clk(clk), .rst_n(rst_n), .strb(strb), .coarse(coarse),
                     .fine(fine), .result(result), .ovf(ovf), .ovf_pos(ovf_pos),
                     .done(done));

  function automatic int merged(input int c, input int f);
    return c * 32 + f - 48;
  endfunction

  function automatic int exp_word(input int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic merge(input int c, input int f, input string req);
    int v;
    int r0;
    v = merged(c, f);
    @(negedge clk);
    strb = 1'b1; coarse = 7'(c); fine = 7'(f);
    @(negedge clk);
    strb = 1'b0;
    chk({req, " word"}, int'(result), exp_word(v));
    chk({req, " ovf"}, int'(ovf), (v < 0 || v > 4095) ? 1 : 0);
    chk({req, " ovf_pos"}, int'(ovf_pos), (v > 4095) ? 1 : 0);
    chk("R5 done high", int'(done), 1);
    r0 = int'(result);
    coarse = 7'($urandom); fine = 7'($urandom);
    @(negedge clk);
    chk("R5 done low", int'(done), 0);
    chk("R6 hold", int'(result), r0);
  endtask

  task automatic model(input int x, input int e);
    int c, f;
    c = (x >>> 5) + e;
    f = x + 48 - 32 * c;
    if (c < 0 || c > 127 || f < 0 || f > 127) return;
    merge(c, f, "R8 model");
    chk("R8 rebuild", int'(result), x);
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 reset word", int'(result), 0);
    chk("R1 reset ovf", int'(ovf | ovf_pos), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle word", int'(result), 0);
    chk("R1 idle done", int'(done), 0);

    merge(64, 48, "R8 midpoint");
    chk("R8 midpoint 2048", int'(result), 2048);
    merge(1, 16, "R2 zero");
    merge(1, 15, "R4 just under");
    merge(0, 0, "R4 floor");
    merge(127, 127, "R3 ceiling");
    merge(127, 79, "R2 top");
    merge(127, 80, "R3 just over");
    merge(10, 100, "R7 in range");
    merge(127, 127, "R3 again");
    merge(50, 60, "R7 clears flags");

    for (int i = 0; i < 4096; i += 37) begin
      model(i, -1); model(i, 0); model(i, 1);
    end
    model(4095, 0);
    for (int i = 0; i < 400; i++)
      merge(int'($urandom % 128), int'($urandom % 128), "R2 random");

    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule